// File: doc/BRIEF.md
# Guard-Bit Fixed-Point DSP ALU

This block is the arithmetic and logic stage of a fixed-point DSP datapath. Its register format is 40 bits wide: an 8-bit guard extension above a 32-bit word. Each operation class reads its own field of that format. Fixed-point add, subtract and compare use the whole 40 bits, or only the low 32 bits when the guard extension is off. Integer increment and decrement use the upper 24 bits, or the upper 16 bits of the word without the guard extension. AND, OR and XOR use the 16-bit field at bits [31:16].

A single condition bit, called DC here, is kept inside the block. Unconditional operations update it. An operation issued with its condition input raised runs only when DC is set, and it never changes DC. Operands, opcode and mode arrive with a valid strobe, and every outcome appears one clock later on registered outputs. The multiplier, the memory transfers and the instruction decode sit outside this block.

The block has no state machine. Its only sequential state is the result register, the DC register and two one-cycle strobes.

Top module: `dsp_guard_alu`

## Requirements
- R1: After reset, `result` is zero, `dc_flag` is 0, and `out_valid` and `wr_en` are 0.
- R2: Every operation accepted with `in_valid` high gives `out_valid` high exactly one cycle later, whatever the opcode. `out_valid` is low in the cycle after a clock with `in_valid` low.
- R3: With `guard_en`=1, opcode 0 (add) writes A+B modulo 2^40 and opcode 1 (subtract) writes A-B modulo 2^40. For an unconditional operation, DC becomes the carry out of bit 39 for add, or the borrow for subtract (1 when A<B unsigned).
- R4: With `guard_en`=0, add and subtract use only bits [31:0] of the operands. The 32-bit result is sign-extended into bits [39:32]. DC becomes the carry or borrow out of bit 31.
- R5: Opcode 2 (compare) computes the borrow of A-B over the active width (40 or 32 bits) and loads it into DC. It writes no result: `wr_en` stays 0 and `result` keeps its value.
- R6: Opcode 3 adds 1 and opcode 4 subtracts 1 on the integer field of A: bits [39:16] when `guard_en`=1, or bits [31:16] when `guard_en`=0. The low 16 result bits are zero. Without the guard extension, the 16-bit field is sign-extended into bits [39:32]. DC becomes the carry or borrow out of the field.
- R7: Opcodes 5, 6 and 7 (AND, OR, XOR) combine bits [31:16] of A and B and write the 16-bit outcome to bits [31:16], with every other bit zero. DC becomes 1 when that 16-bit outcome is zero. `guard_en` has no effect on these opcodes.
- R8: An operation with `cond_en`=1 that is issued while DC=0 writes nothing. `wr_en` is 0, and both `result` and DC keep their values.
- R9: An operation with `cond_en`=1 that is issued while DC=1 writes its result as in R3 to R7, but leaves DC unchanged.
- R10: Opcodes 8 to 15 are undefined. They write no result and leave DC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select (see requirements) |
| guard_en | input | 1 | 1 = use the guard extension (40/24-bit), 0 = 32/16-bit |
| cond_en | input | 1 | 1 = execute only if DC is set, and leave DC alone |
| opnd_a | input | 40 | First operand |
| opnd_b | input | 40 | Second operand |
| out_valid | output | 1 | Outcome strobe, one cycle after `in_valid` |
| wr_en | output | 1 | High with `out_valid` when `result` was written |
| result | output | 40 | Last written result |
| dc_flag | output | 1 | Current DC condition bit |

## Verification
Every outcome comes from one register stage. `result`, `dc_flag`, `wr_en` and `out_valid` for an operation driven at a falling edge are therefore due at the very next falling edge, after one rising edge. The bench drives each operation at a falling edge and checks all four outputs at the following falling edge. It drops `in_valid` only after the check, so consecutive operations issue back to back and none runs twice. Its model tracks DC and the result register across the whole sweep, so conditional operations meet both DC values as earlier operations left them.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_INC = 4'd3,
        OP_DEC = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

endpackage

// File: rtl/dsp_fx_unit.sv
// Fixed-point add or subtract at either the full or the word-only width.
module dsp_fx_unit #(
    parameter int GUARD_W = 8,
    parameter int WORD_W  = 32
) (
    input  logic [GUARD_W+WORD_W-1:0] a,
    input  logic [GUARD_W+WORD_W-1:0] b,
    input  logic                      sub,
    input  logic                      guard_en,
    output logic [GUARD_W+WORD_W-1:0] val,
    output logic                      carry
);
    localparam int REG_W = GUARD_W + WORD_W;

    logic [REG_W:0]  wide;
    logic [WORD_W:0] narrow;

    always_comb begin
        // The extra top bit is the carry for add and the borrow for subtract.
        if (sub) begin
            wide   = {1'b0, a} - {1'b0, b};
            narrow = {1'b0, a[WORD_W-1:0]} - {1'b0, b[WORD_W-1:0]};
        end else begin
            wide   = {1'b0, a} + {1'b0, b};
            narrow = {1'b0, a[WORD_W-1:0]} + {1'b0, b[WORD_W-1:0]};
        end
        if (guard_en) begin
            val   = wide[REG_W-1:0];
            carry = wide[REG_W];
        end else begin
            val   = {{GUARD_W{narrow[WORD_W-1]}}, narrow[WORD_W-1:0]};
            carry = narrow[WORD_W];
        end
    end
endmodule

// File: rtl/dsp_int_unit.sv
// Integer increment or decrement on the upper field of the register.
module dsp_int_unit #(
    parameter int GUARD_W = 8,
    parameter int WORD_W  = 32,
    parameter int FRAC_W  = 16
) (
    input  logic [GUARD_W+WORD_W-FRAC_W-1:0] field,
    input  logic                             dec,
    input  logic                             guard_en,
    output logic [GUARD_W+WORD_W-1:0]        val,
    output logic                             carry
);
    localparam int IW = GUARD_W + WORD_W - FRAC_W;
    localparam int IN = WORD_W - FRAC_W;
    localparam logic [IW:0] ONE_W = (IW+1)'(1);
    localparam logic [IN:0] ONE_N = (IN+1)'(1);

    logic [IW:0] wide;
    logic [IN:0] narrow;

    always_comb begin
        if (dec) begin
            wide   = {1'b0, field} - ONE_W;
            narrow = {1'b0, field[IN-1:0]} - ONE_N;
        end else begin
            wide   = {1'b0, field} + ONE_W;
            narrow = {1'b0, field[IN-1:0]} + ONE_N;
        end
        if (guard_en) begin
            val   = {wide[IW-1:0], {FRAC_W{1'b0}}};
            carry = wide[IW];
        end else begin
            val   = {{GUARD_W{narrow[IN-1]}}, narrow[IN-1:0], {FRAC_W{1'b0}}};
            carry = narrow[IN];
        end
    end
endmodule

// File: rtl/dsp_logic_unit.sv
// Bitwise operations on the 16-bit logical field.
module dsp_logic_unit
    import dsp_alu_pkg::*;
#(
    parameter int GUARD_W = 8,
    parameter int LOGIC_W = 16,
    parameter int FRAC_W  = 16
) (
    input  logic [LOGIC_W-1:0]                a,
    input  logic [LOGIC_W-1:0]                b,
    input  logic_sel_e                        sel,
    output logic [GUARD_W+LOGIC_W+FRAC_W-1:0] val,
    output logic                              zero
);
    logic [LOGIC_W-1:0] r;

    always_comb begin
        unique case (sel)
            LG_AND:  r = a & b;
            LG_OR:   r = a | b;
            default: r = a ^ b;
        endcase
        val  = {{GUARD_W{1'b0}}, r, {FRAC_W{1'b0}}};
        zero = (r == '0);
    end
endmodule

// File: rtl/dsp_guard_alu.sv
module dsp_guard_alu
    import dsp_alu_pkg::*;
#(
    parameter int GUARD_W = 8,
    parameter int WORD_W  = 32,
    parameter int LOGIC_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [3:0]                op_code,
    input  logic                      guard_en,
    input  logic                      cond_en,
    input  logic [GUARD_W+WORD_W-1:0] opnd_a,
    input  logic [GUARD_W+WORD_W-1:0] opnd_b,
    output logic                      out_valid,
    output logic                      wr_en,
    output logic [GUARD_W+WORD_W-1:0] result,
    output logic                      dc_flag
);
    localparam int REG_W  = GUARD_W + WORD_W;
    localparam int FRAC_W = WORD_W - LOGIC_W;

    logic [REG_W-1:0] fx_val, int_val, lg_val, nx_val;
    logic             fx_c, int_c, lg_z, nx_dc;
    logic             is_wr, is_upd, exec_ok, do_write, do_dc;
    logic_sel_e       lg_sel;

    dsp_fx_unit #(.GUARD_W(GUARD_W), .WORD_W(WORD_W)) u_fx (
        .a(opnd_a), .b(opnd_b), .sub(op_code != OP_ADD),
        .guard_en(guard_en), .val(fx_val), .carry(fx_c)
    );

    dsp_int_unit #(.GUARD_W(GUARD_W), .WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_int (
        .field(opnd_a[REG_W-1:FRAC_W]), .dec(op_code == OP_DEC),
        .guard_en(guard_en), .val(int_val), .carry(int_c)
    );

    dsp_logic_unit #(.GUARD_W(GUARD_W), .LOGIC_W(LOGIC_W), .FRAC_W(FRAC_W)) u_lg (
        .a(opnd_a[WORD_W-1:FRAC_W]), .b(opnd_b[WORD_W-1:FRAC_W]),
        .sel(lg_sel), .val(lg_val), .zero(lg_z)
    );

    always_comb begin
        unique case (op_code)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    // Pick the unit's outcome and decide what the operation may write.
    always_comb begin
        nx_val = fx_val;
        nx_dc  = fx_c;
        is_wr  = 1'b0;
        is_upd = 1'b0;
        unique case (op_code)
            OP_ADD, OP_SUB: begin
                is_wr  = 1'b1;
                is_upd = 1'b1;
            end
            OP_CMP: begin
                is_upd = 1'b1;
            end
            OP_INC, OP_DEC: begin
                nx_val = int_val;
                nx_dc  = int_c;
                is_wr  = 1'b1;
                is_upd = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nx_val = lg_val;
                nx_dc  = lg_z;
                is_wr  = 1'b1;
                is_upd = 1'b1;
            end
            default: ;
        endcase
        exec_ok  = !cond_en || dc_flag;
        do_write = in_valid && exec_ok && is_wr;
        do_dc    = in_valid && !cond_en && is_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            result    <= '0;
            dc_flag   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= do_write;
            if (do_write) result  <= nx_val;
            if (do_dc)    dc_flag <= nx_dc;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !wr_en);
    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_code == OP_CMP |=> !wr_en && $stable(result));
    assert_cond_false_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cond_en && !dc_flag |=> !wr_en && $stable(result) && $stable(dc_flag));
    assert_cond_keeps_dc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cond_en |=> $stable(dc_flag));
    assert_undef_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_code[3] |=> !wr_en && $stable(result) && $stable(dc_flag));
    assert_logic_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR)
        && (!cond_en || dc_flag)
        |=> wr_en && result[REG_W-1:WORD_W] == '0 && result[FRAC_W-1:0] == '0);
    assert_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !guard_en && (op_code == OP_ADD || op_code == OP_SUB)
        && (!cond_en || dc_flag)
        |=> result[REG_W-1:WORD_W] == {GUARD_W{result[WORD_W-1]}});
    assert_int_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code == OP_INC || op_code == OP_DEC) && (!cond_en || dc_flag)
        |=> wr_en && result[FRAC_W-1:0] == '0);
endmodule

// File: tb/sim_dsp_guard_alu.sv
`timescale 1ns/1ps
module sim_dsp_guard_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        guard_en = 1'b0;
    logic        cond_en = 1'b0;
    logic [39:0] opnd_a = '0;
    logic [39:0] opnd_b = '0;
    logic        out_valid, wr_en, dc_flag;
    logic [39:0] result;

    int n_run = 0;
    int n_fail = 0;
    logic        m_dc = 1'b0;
    logic [39:0] m_res = '0;

    always #2.5 clk = ~clk;

    dsp_guard_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .guard_en(guard_en), .cond_en(cond_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .wr_en(wr_en), .result(result), .dc_flag(dc_flag)
    );

    function automatic logic [39:0] pick(input int i);
        case (i)
            0: pick = 40'h00_0000_0000;
            1: pick = 40'h00_0000_0001;
            2: pick = 40'hFF_FFFF_FFFF;
            3: pick = 40'h7F_FFFF_FFFF;
            4: pick = 40'h80_0000_0000;
            5: pick = 40'h00_FFFF_FFFF;
            6: pick = 40'h00_8000_0000;
            default: pick = 40'h12_A5C3_789A;
        endcase
    endfunction

    function automatic logic [39:0] sx32(input logic [31:0] v);
        return {{8{v[31]}}, v};
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model computed from the requirements.
    task automatic model(input logic [39:0] a, input logic [39:0] b, input logic [3:0] op,
                         input logic g, input logic c, output logic w, output string req);
        longint unsigned ua = 64'(a), ub = 64'(b);
        longint unsigned la = 64'(a[31:0]), lb = 64'(b[31:0]);
        longint unsigned s;
        logic [23:0] f24;
        logic [15:0] f16;
        logic [39:0] nr = '0;
        logic nd = 1'b0, wr = 1'b0, upd = 1'b0;
        f24 = a[39:16];
        f16 = a[31:16];
        req = "R10";
        case (op)
            4'd0: begin
                wr = 1; upd = 1;
                if (g) begin s = ua + ub; nr = s[39:0]; nd = (s >= 64'h100_0000_0000); req = "R3"; end
                else   begin s = la + lb; nr = sx32(s[31:0]); nd = (s >= 64'h1_0000_0000); req = "R4"; end
            end
            4'd1, 4'd2: begin
                wr = (op == 4'd1); upd = 1;
                if (g) begin s = ua - ub; nr = s[39:0]; nd = (ua < ub); end
                else   begin s = la - lb; nr = sx32(s[31:0]); nd = (la < lb); end
                req = (op == 4'd2) ? "R5" : (g ? "R3" : "R4");
            end
            4'd3: begin
                wr = 1; upd = 1; req = "R6";
                if (g) begin nr = {f24 + 24'd1, 16'h0}; nd = (f24 == 24'hFF_FFFF); end
                else   begin nr = sx32({f16 + 16'd1, 16'h0}); nd = (f16 == 16'hFFFF); end
            end
            4'd4: begin
                wr = 1; upd = 1; req = "R6";
                if (g) begin nr = {f24 - 24'd1, 16'h0}; nd = (f24 == 24'h0); end
                else   begin nr = sx32({f16 - 16'd1, 16'h0}); nd = (f16 == 16'h0); end
            end
            4'd5, 4'd6, 4'd7: begin
                logic [15:0] r;
                wr = 1; upd = 1; req = "R7";
                r = (op == 4'd5) ? (a[31:16] & b[31:16]) :
                    (op == 4'd6) ? (a[31:16] | b[31:16]) : (a[31:16] ^ b[31:16]);
                nr = {8'h0, r, 16'h0};
                nd = (r == 16'h0);
            end
            default: ;
        endcase
        if (c) req = m_dc ? {req, "/R9"} : "R8";
        w = 1'b0;
        if (wr && (!c || m_dc)) begin m_res = nr; w = 1'b1; end
        if (upd && !c) m_dc = nd;
    endtask

    // Called at a falling edge; checks at the next falling edge.
    task automatic run_op(input logic [39:0] a, input logic [39:0] b, input logic [3:0] op,
                          input logic g, input logic c);
        logic w;
        string req;
        opnd_a = a; opnd_b = b; op_code = op; guard_en = g; cond_en = c; in_valid = 1'b1;
        model(a, b, op, g, c, w, req);
        @(negedge clk);
        check({"R2 ", req}, 40'(out_valid), 40'(1'b1));
        check(req, 40'(wr_en), 40'(w));
        check(req, result, m_res);
        check(req, 40'(dc_flag), 40'(m_dc));
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", result, 40'h0);
        check("R1", 40'(dc_flag), 40'h0);
        check("R1", 40'({out_valid, wr_en}), 40'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", 40'({out_valid, wr_en}), 40'h0);
        // Full sweep: every operand pair, opcode, guard mode and condition mode.
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int op = 0; op < 16; op++)
                    for (int m = 0; m < 4; m++)
                        run_op(pick(i), pick(j), 4'(op), m[0], m[1]);
        @(negedge clk);
        check("R2 idle", 40'(out_valid), 40'h0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule